// File: doc/BRIEF.md
# Oscillator Frequency Deviation Detector

This block measures the frequency of a square wave produced by an LC sensor oscillator and its comparator. Metal near the sensor coil shifts the oscillator frequency. The block counts the rising edges of the sensor wave over a fixed number of system clock cycles and compares that count with an expected value. If the two differ by more than a tolerance, it raises a metal flag.

The sensor wave is asynchronous to the system clock. It passes through a synchronizer, and its rising edges are detected in the clock domain; the wave never drives a clock pin. A reference counter on the system clock sets the length of the gate window. When the window ends, the block registers the measured count and the metal decision and pulses `done`. In the next cycle a single control path clears both counters, and the following window starts without any intervention. The window length, expected count and tolerance are inputs, so a host can calibrate the detector against bare ground.

Top module: `freq_dev_detector`

## Requirements
- R1: While `rst` is high at a clock edge, `metal`, `done` and `meas_cnt` become 0 at that edge. The clear is synchronous.
- R2: `done` is high for exactly one clock cycle at the end of each window. Consecutive `done` pulses are exactly `win_len` cycles apart.
- R3: At each `done`, `meas_cnt` holds the number of sensor rising edges seen during the window just ended. Each edge is counted once, provided the sensor stays high and low for at least one clock cycle each.
- R4: A sensor edge that is detected in the cycle in which the counters are cleared is counted in the new window and is never lost. With a sensor period that divides `win_len` exactly, every window therefore reports `win_len / period`.
- R5: `metal` is updated together with `done`. It is 1 when the absolute difference between the measured count and `exp_cnt` is strictly greater than `tol`, and 0 when the difference equals `tol` or is smaller. This holds whether the count is above or below `exp_cnt`.
- R6: Between `done` pulses, `metal` and `meas_cnt` hold their values.
- R7: A `win_len` of 0 or 1 gives the same behaviour as a `win_len` of 2.
- R8: If `win_len` is lowered below the number of cycles already elapsed in the current window, that window ends within two cycles instead of counting on toward the counter limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sense_in | input | 1 | Asynchronous square wave from the sensor comparator |
| win_len | input | 11 | Gate window length in clock cycles |
| exp_cnt | input | 11 | Edge count expected with no metal present |
| tol | input | 11 | Largest deviation still accepted as no metal |
| metal | output | 1 | Metal detected in the last completed window |
| meas_cnt | output | 11 | Edge count of the last completed window |
| done | output | 1 | One-cycle pulse at each window end |

## Verification
The bench sweeps sensor periods against window lengths that are exact multiples of the period. It does this at several phase alignments, so that in some runs a sensor edge falls in the clear cycle and in others it does not. A design that dropped or double-counted that edge would report one count too few or too many. The comparison is tested on both sides of the expected count and exactly at the tolerance boundary, where a `>=` comparison in place of `>` would flag metal wrongly. Degenerate window lengths of 0 and 1, and a window length cut short mid-window, catch a reference counter that wraps through its whole range instead of ending promptly.

// File: rtl/freq_dev_detector.sv
module freq_dev_detector #(
  parameter int CW   = 11,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sense_in,
  input  logic [CW-1:0] win_len,
  input  logic [CW-1:0] exp_cnt,
  input  logic [CW-1:0] tol,
  output logic          metal,
  output logic [CW-1:0] meas_cnt,
  output logic          done
);
  localparam logic [CW:0]   MIN_WIN = (CW+1)'(2);
  localparam logic [CW:0]   ONE_W   = (CW+1)'(1);
  localparam logic [CW-1:0] ONE     = CW'(1);

  logic [SYNC:0]   sh;
  logic            rise;
  logic            clr;
  logic [CW-1:0]   ref_cnt;
  logic [CW-1:0]   edge_cnt;
  logic [CW-1:0]   edge_nxt;
  logic [CW-1:0]   dev;
  logic [CW:0]     win_eff;
  logic            end_win;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC-1:0], sense_in};
  end

  assign rise     = sh[SYNC-1] & ~sh[SYNC];
  assign edge_nxt = edge_cnt + {{(CW-1){1'b0}}, rise};
  assign win_eff  = ({1'b0, win_len} < MIN_WIN) ? MIN_WIN : {1'b0, win_len};
  assign end_win  = !clr && (({1'b0, ref_cnt} + ONE_W) >= win_eff);
  assign dev      = (edge_nxt >= exp_cnt) ? (edge_nxt - exp_cnt) : (exp_cnt - edge_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      clr      <= 1'b1;
      ref_cnt  <= '0;
      edge_cnt <= '0;
      meas_cnt <= '0;
      metal    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= end_win;
      if (clr) begin
        clr      <= 1'b0;
        ref_cnt  <= ONE;
        edge_cnt <= {{(CW-1){1'b0}}, rise};
      end else if (end_win) begin
        clr      <= 1'b1;
        ref_cnt  <= ref_cnt + ONE;
        meas_cnt <= edge_nxt;
        metal    <= (dev > tol);
      end else begin
        ref_cnt  <= ref_cnt + ONE;
        edge_cnt <= edge_nxt;
      end
    end
  end
endmodule

// File: rtl/freq_dev_detector_chk.sv
module freq_dev_detector_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          metal,
  input logic [CW-1:0] meas_cnt,
  input logic          done,
  input logic [CW-1:0] exp_cnt,
  input logic [CW-1:0] tol
);
  function automatic logic [CW-1:0] absd(input logic [CW-1:0] a, input logic [CW-1:0] b);
    return (a >= b) ? (a - b) : (b - a);
  endfunction

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!done && !metal && meas_cnt == '0));

  a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(rst)) |=> !done);

  a_r6_metal_hold: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(metal));

  a_r6_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(meas_cnt));

  a_r5_flag_rule: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(rst) && $stable(exp_cnt) && $stable(tol))
      |-> (metal == (absd(meas_cnt, exp_cnt) > tol)));
endmodule

bind freq_dev_detector freq_dev_detector_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .metal(metal), .meas_cnt(meas_cnt),
  .done(done), .exp_cnt(exp_cnt), .tol(tol)
);

// File: tb/freq_dev_detector_tb.sv
module freq_dev_detector_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sense_in;
  logic [10:0] win_len = 11'd8;
  logic [10:0] exp_cnt = '0;
  logic [10:0] tol = '0;
  logic        metal;
  logic [10:0] meas_cnt;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int per    = 0;
  int ph     = 0;

  always #5 clk = ~clk;

  freq_dev_detector u_dut (
    .clk(clk), .rst(rst), .sense_in(sense_in), .win_len(win_len),
    .exp_cnt(exp_cnt), .tol(tol), .metal(metal), .meas_cnt(meas_cnt), .done(done)
  );

  always @(negedge clk) begin
    if (per != 0) ph <= (ph + 1 >= per) ? 0 : ph + 1;
    else          ph <= 0;
  end
  assign sense_in = (per != 0) && (ph < (per >> 1));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wait_done(output int gap, input bit chk_low);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
      if (gap == 1 && chk_low) chk(!done, "R2 done width", int'(done), 0);
      if (gap > 6000) begin
        chk(0, "R2 done missing", gap, 0);
        break;
      end
    end while (!done);
  endtask

  task automatic run_cfg(input int p, input int wl, input int e, input int t, input int ncnt);
    int gap;
    bit expm;
    int dv;
    @(negedge clk);
    per = p; win_len = 11'(wl); exp_cnt = 11'(e); tol = 11'(t);
    wait_done(gap, 0);
    wait_done(gap, 1);
    wait_done(gap, 1);
    dv   = (ncnt >= e) ? ncnt - e : e - ncnt;
    expm = dv > t;
    for (int w = 0; w < 3; w++) begin
      wait_done(gap, 1);
      chk(gap == ((wl < 2) ? 2 : wl), "R2 period", gap, (wl < 2) ? 2 : wl);
      chk(meas_cnt == 11'(ncnt), "R3 R4 edge count", int'(meas_cnt), ncnt);
      chk(metal == expm, "R5 metal flag", int'(metal), int'(expm));
    end
  endtask

  initial begin
    #1900000;
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    chk(!done && !metal && meas_cnt == 0, "R1 reset state", int'(meas_cnt), 0);
    rst = 1'b0;

    for (int p = 2; p <= 5; p++) begin
      for (int ki = 0; ki < 4; ki++) begin
        int k;
        k = (ki == 0) ? 1 : (ki == 1) ? 2 : (ki == 2) ? 3 : 7;
        run_cfg(p, p * k, k, 0, k);
        run_cfg(p, p * k, k + 1, 1, k);
        run_cfg(p, p * k, k + 2, 1, k);
        if (k >= 3) run_cfg(p, p * k, k - 3, 2, k);
        if (k >= 2) run_cfg(p, p * k, k - 2, 2, k);
      end
    end

    // R7: degenerate window lengths
    run_cfg(2, 0, 1, 0, 1);
    run_cfg(2, 1, 1, 0, 1);

    // R6: outputs held mid-window
    run_cfg(4, 40, 3, 0, 10);
    begin
      logic [10:0] mc;
      logic        mf;
      mc = meas_cnt; mf = metal;
      repeat (20) @(negedge clk);
      chk(meas_cnt == mc, "R6 count held", int'(meas_cnt), int'(mc));
      chk(metal == mf, "R6 flag held", int'(metal), int'(mf));
    end

    // R8: window shortened below elapsed cycles
    @(negedge clk);
    per = 4; win_len = 11'd400; exp_cnt = 11'd2; tol = 11'd0;
    wait_done(gap, 0);
    repeat (100) @(negedge clk);
    win_len = 11'd8;
    wait_done(gap, 0);
    chk(gap <= 2, "R8 early end", gap, 2);
    wait_done(gap, 1);
    wait_done(gap, 1);
    chk(gap == 8, "R8 new period", gap, 8);
    chk(meas_cnt == 11'd2, "R8 count", int'(meas_cnt), 2);

    // R1: reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!done && !metal && meas_cnt == 0, "R1 mid-run reset", int'(meas_cnt), 0);
    rst = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule